// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Port

This block is one general-purpose I/O port of a small microcontroller. It has `WIDTH` pins. Each pin has three register bits: a direction bit, a drive/pull bit and a sampled input bit. The CPU reaches them at three separate addresses on a simple bus with a write strobe, a read strobe, an address and a data bus. On the pad side, each pin has a drive level, a drive enable, a pull-up request and a raw input.

The drive/pull bit has two uses. When the pin is set as an output, the bit is the level driven onto the pad. When the pin is set as an input, the bit requests the internal pull-up. A chip-wide pull-up kill input removes every pull-up, whatever the registers hold. The raw pad level passes through a reset-cleared synchronizer chain of `SYNC_STAGES` flops before the CPU can read it. While the sleep input is high, the chain is fed zeros, so floating pads cannot toggle internal nodes. Reset is asynchronous: it releases every pad at once, even when no clock is running.

Top module: `gpio_port`

## Requirements
- R1: Addresses decode as direction = 0, drive/pull = 1, pin sample = 2. A write takes effect at the rising clock edge when `wr_en` is high. `rdata` is combinational and is valid while `rd_en` is high. `rdata` is 0 when `rd_en` is low or when the address is unmapped (3).
- R2: `pad_oe[i]` equals direction bit i, so 1 means output and 0 means input.
- R3: When direction bit i is 1, `pad_out[i]` equals drive/pull bit i. When direction bit i is 0, `pad_out[i]` is 0.
- R4: `pad_pu[i]` is 1 only when direction bit i is 0, drive/pull bit i is 1 and `pu_kill` is 0.
- R5: `rst_n` low clears both registers and the synchronizer at once, without a clock edge. While reset is held, `pad_oe`, `pad_out` and `pad_pu` are all 0.
- R6: A read of the pin address returns the level that `pad_in` had at the rising edge two edges earlier. A read one edge after a change still returns the old value.
- R7: While `sleep` is high, the synchronizer input is forced to 0, so pin reads become 0 after two edges. Writes, drive and pull-ups are unaffected, and the pad level is visible again two edges after `sleep` falls.
- R8: Writes to the pin address or to the unmapped address change neither register nor any pad output.
- R9: Reads of the direction and drive/pull addresses return the stored register values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data, 0 when not reading |
| pu_kill | input | 1 | Chip-wide pull-up disable |
| sleep | input | 1 | Sleep request, gates the input chain |
| pad_in | input | WIDTH | Raw pad levels |
| pad_out | output | WIDTH | Pad drive levels |
| pad_oe | output | WIDTH | Pad drive enables |
| pad_pu | output | WIDTH | Pad pull-up requests |

## Verification
The bound checker watches several properties on every cycle. It checks that the pad controls follow each register write. It checks that no pin both drives and pulls, and that the kill input removes all pull-ups. It checks that pin-address writes leave the pads untouched, and that reset releases every pad. It also checks that a stable pad or a long sleep yields the expected pin read. Only the bench scenarios can show some other points: the exact edge at which a pad change first becomes readable, that the release happens before any clock edge once reset is asserted, and the readback values for specific register patterns.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   typedef enum logic [1:0] {
      SEL_DIR  = 2'd0,
      SEL_DRV  = 2'd1,
      SEL_PIN  = 2'd2,
      SEL_NONE = 2'd3
   } gpio_sel_e;

   function automatic gpio_sel_e gpio_decode(input logic [7:0] a,
                                             input logic [7:0] dir_a,
                                             input logic [7:0] drv_a,
                                             input logic [7:0] pin_a);
      if (a == dir_a)      return SEL_DIR;
      else if (a == drv_a) return SEL_DRV;
      else if (a == pin_a) return SEL_PIN;
      else                 return SEL_NONE;
   endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_dir,
   input  logic             we_drv,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] drv_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (we_dir) begin
         dir_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q <= '0;
      end else if (we_drv) begin
         drv_q <= wdata;
      end
   end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pin_q
);

   logic [STAGES-1:0][WIDTH-1:0] chain;
   logic [WIDTH-1:0]             gated;

   // Sleep parks the first flop at zero so open pads cannot toggle it.
   assign gated = sleep ? '0 : pad_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], gated};
      end
   end

   assign pin_q = chain[STAGES-1];

endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] drv_q,
   input  logic             pu_kill,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_pu
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      // One stored bit: drive level for outputs, pull request for inputs.
      assign pad_oe[i]  = dir_q[i];
      assign pad_out[i] = dir_q[i] & drv_q[i];
      assign pad_pu[i]  = ~dir_q[i] & drv_q[i] & ~pu_kill;
   end

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
   import gpio_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             rd_en,
   input  gpio_sel_e        sel,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] drv_q,
   input  logic [WIDTH-1:0] pin_q,
   output logic [WIDTH-1:0] rdata
);

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (sel)
            SEL_DIR: rdata = dir_q;
            SEL_DRV: rdata = drv_q;
            SEL_PIN: rdata = pin_q;
            default: rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int DIR_ADDR    = 0,
   parameter int DRV_ADDR    = 1,
   parameter int PIN_ADDR    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  rdata,
   input  logic              pu_kill,
   input  logic              sleep,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_pu
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_port: WIDTH must be at least 1");
   end
   if (ADDR_W < 2 || ADDR_W > 8) begin : g_bad_addr_w
      $error("gpio_port: ADDR_W must lie in 2..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port: SYNC_STAGES must be at least 2");
   end
   if (DIR_ADDR >= ADDR_SPAN || DRV_ADDR >= ADDR_SPAN || PIN_ADDR >= ADDR_SPAN) begin : g_bad_map
      $error("gpio_port: register address outside the address span");
   end
   if (DIR_ADDR == DRV_ADDR || DIR_ADDR == PIN_ADDR || DRV_ADDR == PIN_ADDR) begin : g_dup_map
      $error("gpio_port: register addresses must be distinct");
   end

   gpio_sel_e        sel;
   logic             we_dir;
   logic             we_drv;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] drv_q;
   logic [WIDTH-1:0] pin_q;

   always_comb begin
      sel = gpio_decode(8'(addr), 8'(DIR_ADDR), 8'(DRV_ADDR), 8'(PIN_ADDR));
   end

   assign we_dir = wr_en && (sel == SEL_DIR);
   assign we_drv = wr_en && (sel == SEL_DRV);

   gpio_regfile #(.WIDTH(WIDTH)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_dir (we_dir),
      .we_drv (we_drv),
      .wdata  (wdata),
      .dir_q  (dir_q),
      .drv_q  (drv_q)
   );

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sleep  (sleep),
      .pad_in (pad_in),
      .pin_q  (pin_q)
   );

   gpio_padctl #(.WIDTH(WIDTH)) u_pad (
      .dir_q   (dir_q),
      .drv_q   (drv_q),
      .pu_kill (pu_kill),
      .pad_out (pad_out),
      .pad_oe  (pad_oe),
      .pad_pu  (pad_pu)
   );

   gpio_rdmux #(.WIDTH(WIDTH)) u_rd (
      .rd_en (rd_en),
      .sel   (sel),
      .dir_q (dir_q),
      .drv_q (drv_q),
      .pin_q (pin_q),
      .rdata (rdata)
   );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int WIDTH       = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int DIR_ADDR    = 0,
   parameter int DRV_ADDR    = 1,
   parameter int PIN_ADDR    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              rd_en,
   input logic [WIDTH-1:0]  wdata,
   input logic [WIDTH-1:0]  rdata,
   input logic              pu_kill,
   input logic              sleep,
   input logic [WIDTH-1:0]  pad_in,
   input logic [WIDTH-1:0]  pad_out,
   input logic [WIDTH-1:0]  pad_oe,
   input logic [WIDTH-1:0]  pad_pu
);

   localparam int CW = $clog2(SYNC_STAGES + 1) + 1;

   logic [CW-1:0]    calm_cnt;
   logic [CW-1:0]    nap_cnt;
   logic [WIDTH-1:0] prev_pad;

   // Counts edges at which the pad held still while awake.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         calm_cnt <= '0;
         nap_cnt  <= '0;
         prev_pad <= '0;
      end else begin
         prev_pad <= pad_in;
         if (sleep || pad_in != prev_pad) calm_cnt <= '0;
         else if (calm_cnt < CW'(SYNC_STAGES)) calm_cnt <= calm_cnt + 1'b1;
         if (!sleep) nap_cnt <= '0;
         else if (nap_cnt < CW'(SYNC_STAGES)) nap_cnt <= nap_cnt + 1'b1;
      end
   end

   assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == ADDR_W'(DIR_ADDR) |=> pad_oe == $past(wdata));

   assert_drive_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == ADDR_W'(DRV_ADDR) |=> (pad_out == ($past(wdata) & pad_oe)));

   assert_no_drive_on_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

   assert_pull_only_inputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == '0);

   assert_pull_kill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pu_kill |-> pad_pu == '0);

   assert_reset_release_R5: assert property (@(posedge clk)
      !rst_n |-> (pad_oe == '0 && pad_out == '0 && pad_pu == '0));

   assert_pin_settled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == ADDR_W'(PIN_ADDR) && calm_cnt >= CW'(SYNC_STAGES) && pad_in == prev_pad
      |-> rdata == pad_in);

   assert_sleep_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == ADDR_W'(PIN_ADDR) && nap_cnt >= CW'(SYNC_STAGES) |-> rdata == '0);

   assert_pin_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr != ADDR_W'(DIR_ADDR) && addr != ADDR_W'(DRV_ADDR)
      |=> $stable(pad_oe) && $stable(pad_out));

endmodule

bind gpio_port gpio_port_chk #(
   .WIDTH(WIDTH), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
   .DIR_ADDR(DIR_ADDR), .DRV_ADDR(DRV_ADDR), .PIN_ADDR(PIN_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
   .wdata(wdata), .rdata(rdata), .pu_kill(pu_kill), .sleep(sleep),
   .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   addr = '0;
   logic         wr_en = 1'b0;
   logic         rd_en = 1'b0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         pu_kill = 1'b0;
   logic         sleep = 1'b0;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] pad_out;
   logic [W-1:0] pad_oe;
   logic [W-1:0] pad_pu;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_port u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .pu_kill(pu_kill), .sleep(sleep),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
      addr = a; rd_en = 1'b1;
      #1 v = rdata;
      rd_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      repeat (3) @(negedge clk);
      chk("R5 oe in reset", pad_oe, 8'h00);
      chk("R5 pu in reset", pad_pu, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      rd(2'd0, v); chk("R9 dir after reset", v, 8'h00);
      rd(2'd1, v); chk("R9 drv after reset", v, 8'h00);
   endtask

   task automatic t_regs();
      logic [W-1:0] v;
      wr(2'd0, 8'h0F);
      wr(2'd1, 8'h3C);
      rd(2'd0, v); chk("R9 dir readback", v, 8'h0F);
      rd(2'd1, v); chk("R9 drv readback", v, 8'h3C);
      chk("R2 oe follows dir", pad_oe, 8'h0F);
      chk("R3 drive level", pad_out, 8'h0C);
      chk("R4 pull on inputs", pad_pu, 8'h30);
      wr(2'd1, 8'hC3);
      chk("R3 drive level 2", pad_out, 8'h03);
      chk("R4 pull on inputs 2", pad_pu, 8'hC0);
      wr(2'd1, 8'h3C);
   endtask

   task automatic t_kill();
      @(negedge clk); pu_kill = 1'b1;
      #1 chk("R4 kill clears pulls", pad_pu, 8'h00);
      chk("R4 kill leaves drive", pad_out, 8'h0C);
      @(negedge clk); pu_kill = 1'b0;
      #1 chk("R4 pulls back", pad_pu, 8'h30);
   endtask

   task automatic t_bus();
      logic [W-1:0] v;
      @(negedge clk);
      rd(2'd3, v); chk("R1 unmapped read", v, 8'h00);
      addr = 2'd0; #1 chk("R1 no read strobe", rdata, 8'h00);
   endtask

   task automatic t_ignored();
      logic [W-1:0] v;
      wr(2'd2, 8'hFF);
      wr(2'd3, 8'hA0);
      rd(2'd0, v); chk("R8 dir kept", v, 8'h0F);
      rd(2'd1, v); chk("R8 drv kept", v, 8'h3C);
      chk("R8 oe kept", pad_oe, 8'h0F);
      chk("R8 out kept", pad_out, 8'h0C);
   endtask

   task automatic t_latency();
      logic [W-1:0] v;
      @(negedge clk); pad_in = 8'h5A;
      rd(2'd2, v); chk("R6 before any edge", v, 8'h00);
      @(posedge clk); rd(2'd2, v); chk("R6 after one edge", v, 8'h00);
      @(posedge clk); rd(2'd2, v); chk("R6 after two edges", v, 8'h5A);
      @(negedge clk); pad_in = 8'hC3;
      @(posedge clk); rd(2'd2, v); chk("R6 second pattern one edge", v, 8'h5A);
      @(posedge clk); rd(2'd2, v); chk("R6 second pattern two edges", v, 8'hC3);
   endtask

   task automatic t_sleep();
      logic [W-1:0] v;
      @(negedge clk); pad_in = 8'hA5;
      repeat (3) @(negedge clk);
      rd(2'd2, v); chk("R7 awake level", v, 8'hA5);
      @(negedge clk); sleep = 1'b1;
      @(posedge clk); rd(2'd2, v); chk("R7 one sleep edge", v, 8'hA5);
      @(posedge clk); rd(2'd2, v); chk("R7 asleep reads zero", v, 8'h00);
      chk("R7 oe held", pad_oe, 8'h0F);
      chk("R7 pull held", pad_pu, 8'h30);
      wr(2'd1, 8'h3F);
      chk("R7 write while asleep", pad_out, 8'h0F);
      wr(2'd1, 8'h3C);
      @(negedge clk); sleep = 1'b0;
      @(posedge clk); @(posedge clk);
      rd(2'd2, v); chk("R7 wake shows pad", v, 8'hA5);
   endtask

   task automatic t_async();
      logic [W-1:0] v;
      wr(2'd0, 8'hF0);
      wr(2'd1, 8'hAA);
      chk("R5 preset oe", pad_oe, 8'hF0);
      @(negedge clk);
      #1 rst_n = 1'b0;
      #1 chk("R5 oe cleared without edge", pad_oe, 8'h00);
      chk("R5 out cleared without edge", pad_out, 8'h00);
      chk("R5 pu cleared without edge", pad_pu, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      rd(2'd1, v); chk("R5 drv cleared", v, 8'h00);
      rd(2'd2, v); chk("R5 sync cleared", v, 8'h00);
   endtask

   initial begin
      t_reset();
      t_regs();
      t_kill();
      t_bus();
      t_ignored();
      t_latency();
      t_sleep();
      t_async();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule